// File: doc/BRIEF.md
# Instruction Cycle Timing Generator

This block produces the processor-side timing for a bus on which every slave device acts on a broadcast command code. It counts a free-running phase clock into instruction cycles that last either four clocks (short) or six clocks (long). The last clock of every cycle carries a write strobe, and the falling edge of that strobe ends the cycle. A 5-bit bus command is registered at the start of each cycle and held unchanged until the cycle ends, so each cycle carries exactly one command.

The control unit gives the command for the next cycle on `next_cmd` and asks for a long cycle on `long_req`. Both are sampled only on the clock edge that ends the current cycle. A one-clock `cycle_start` pulse marks the first clock of each cycle so that the control unit can line up its own sequencing. After reset the block opens a short cycle that carries command 0x00, the opcode fetch, so that the first instruction is fetched.

The sequencer has three named states. `PH_OPEN` is the first clock of a cycle. `PH_BODY` covers the middle clocks: two in a short cycle, four in a long one. `PH_STROBE` is the final clock. The transitions are OPEN→BODY (always taken), BODY→BODY (while middle clocks remain), BODY→STROBE (when the middle count runs out) and STROBE→OPEN (always taken, and this is where the next cycle's command and length are loaded).

Top module: `cyc_timer`

## Requirements
- R1: A cycle whose `long_req` sampled 0 lasts exactly 4 clocks, counted from its `cycle_start` clock to its `wr_strobe` clock inclusive.
- R2: A cycle whose `long_req` sampled 1 lasts exactly 6 clocks, counted the same way.
- R3: `wr_strobe` is high in the final clock of every cycle and low in every other clock, so it stays high for exactly one clock.
- R4: `cycle_start` is high in the first clock of every cycle and low in every other clock, and it is never high in the same clock as `wr_strobe`.
- R5: `cmd_out` takes the new command in the first clock of a cycle and keeps that value through every clock of the cycle.
- R6: `next_cmd` and `long_req` are sampled only on the rising edge at the end of a clock in which `wr_strobe` is high. Values present at any other edge have no effect on `cmd_out` or on cycle length.
- R7: While `rst` (synchronous, active high) is high, and in the first clock after it is released, `cycle_start` is 1, `wr_strobe` is 0 and `cmd_out` is 0x00. That first cycle is short.
- R8: Cycles run back to back. The clock after a `wr_strobe` clock is always the first clock of the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Phase clock |
| rst | input | 1 | Synchronous reset, active high |
| next_cmd | input | 5 | Command code for the next cycle |
| long_req | input | 1 | 1 asks for a 6-clock next cycle, 0 for a 4-clock one |
| wr_strobe | output | 1 | High in the final clock of each cycle |
| cmd_out | output | 5 | Command code of the current cycle |
| cycle_start | output | 1 | High in the first clock of each cycle |

## Verification
The bench changes `next_cmd` and `long_req` on every clock, including the middle of cycles. A design that sampled them anywhere other than the strobe clock would change `cmd_out` inside a cycle or give the wrong length. Short and long cycles are mixed in every order, long after short and short after long. This catches a middle counter that is reloaded from the stale length and gives a 5-clock or 7-clock cycle. A reset applied in the middle of a long cycle must restart a short cycle carrying 0x00. A design that kept the old length or command, or left a gap clock between cycles, would fail the per-clock comparison.

// File: rtl/cyc_pkg.sv
package cyc_pkg;
    typedef enum logic [1:0] {
        PH_OPEN   = 2'd0,
        PH_BODY   = 2'd1,
        PH_STROBE = 2'd2
    } cyc_phase_e;
endpackage

// File: rtl/cyc_seq.sv
module cyc_seq
    import cyc_pkg::*;
#(
    parameter int SHORT_LEN = 4,
    parameter int LONG_LEN  = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       long_cur,
    output cyc_phase_e phase_o,
    output logic       last_o
);
    localparam int LEN_W = $clog2(LONG_LEN + 1);
    localparam logic [LEN_W-1:0] SHORT_MID = LEN_W'(SHORT_LEN - 3);
    localparam logic [LEN_W-1:0] LONG_MID  = LEN_W'(LONG_LEN - 3);

    cyc_phase_e       state, state_nx;
    logic [LEN_W-1:0] mid_cnt;

    always_comb begin
        state_nx = state;
        unique case (state)
            PH_OPEN:   state_nx = PH_BODY;
            PH_BODY:   state_nx = (mid_cnt == '0) ? PH_STROBE : PH_BODY;
            PH_STROBE: state_nx = PH_OPEN;
            default:   state_nx = PH_OPEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= PH_OPEN;
            mid_cnt <= '0;
        end else begin
            state <= state_nx;
            if (state == PH_OPEN)
                mid_cnt <= long_cur ? LONG_MID : SHORT_MID;
            else if (state == PH_BODY && mid_cnt != '0)
                mid_cnt <= mid_cnt - 1'b1;
        end
    end

    always_comb begin
        phase_o = state;
        last_o  = (state == PH_STROBE);
    end

    // R8: the strobe clock is always followed by the opening clock
    p_back_to_back_r8: assert property (@(posedge clk) disable iff (rst)
        state == PH_STROBE |=> state == PH_OPEN);
    // R4: the opening clock is always followed by a middle clock
    p_open_once_r4: assert property (@(posedge clk) disable iff (rst)
        state == PH_OPEN |=> state == PH_BODY);
endmodule

// File: rtl/cyc_cmd_hold.sv
module cyc_cmd_hold #(
    parameter int CMD_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             long_in,
    input  logic [CMD_W-1:0] cmd_in,
    output logic             long_q,
    output logic [CMD_W-1:0] cmd_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            long_q <= 1'b0;
            cmd_q  <= '0;
        end else if (load) begin
            long_q <= long_in;
            cmd_q  <= cmd_in;
        end
    end

    // R6: nothing is taken in except on the strobe clock
    p_hold_cmd_r6: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(cmd_q) && $stable(long_q));
endmodule

// File: rtl/cyc_timer.sv
module cyc_timer
    import cyc_pkg::*;
#(
    parameter int CMD_W     = 5,
    parameter int SHORT_LEN = 4,
    parameter int LONG_LEN  = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CMD_W-1:0] next_cmd,
    input  logic             long_req,
    output logic             wr_strobe,
    output logic [CMD_W-1:0] cmd_out,
    output logic             cycle_start
);
    localparam int LEN_W = $clog2(LONG_LEN + 1);

    cyc_phase_e phase;
    logic       last_clk;
    logic       long_cur;

    cyc_seq #(.SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .long_cur (long_cur),
        .phase_o  (phase),
        .last_o   (last_clk)
    );

    cyc_cmd_hold #(.CMD_W(CMD_W)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .load    (last_clk),
        .long_in (long_req),
        .cmd_in  (next_cmd),
        .long_q  (long_cur),
        .cmd_q   (cmd_out)
    );

    always_comb begin
        wr_strobe   = (phase == PH_STROBE);
        cycle_start = (phase == PH_OPEN);
    end

    // Clock count since the current cycle opened
    logic [LEN_W-1:0] age;
    always_ff @(posedge clk) begin
        if (rst)              age <= '0;
        else if (cycle_start) age <= LEN_W'(1);
        else                  age <= age + 1'b1;
    end

    // R1 and R2: the strobe lands in clock SHORT_LEN or LONG_LEN of the cycle
    p_cycle_len_r1: assert property (@(posedge clk) disable iff (rst)
        wr_strobe |-> age == (long_cur ? LEN_W'(LONG_LEN - 1) : LEN_W'(SHORT_LEN - 1)));
    // R3 and R4: strobe and start never share a clock
    p_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_strobe, cycle_start}));
    // R5: the command stays put through every clock after the opening one
    p_cmd_stable_r5: assert property (@(posedge clk) disable iff (rst)
        !wr_strobe |=> $stable(cmd_out));
    // R7: the first clock after reset opens a cycle carrying 0x00
    p_reset_open_r7: assert property (@(posedge clk)
        rst |=> cycle_start && cmd_out == '0 && !wr_strobe);
endmodule

// File: tb/sim_cyc_timer.sv
`timescale 1ns/1ps
module sim_cyc_timer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] next_cmd = 5'd0;
    logic       long_req = 1'b0;
    logic       wr_strobe, cycle_start;
    logic [4:0] cmd_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    cyc_timer u0 (
        .clk(clk), .rst(rst), .next_cmd(next_cmd), .long_req(long_req),
        .wr_strobe(wr_strobe), .cmd_out(cmd_out), .cycle_start(cycle_start)
    );

    // behavioural reference
    int ref_len = 4;
    int ref_ph  = 0;
    int ref_cmd = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    task automatic step_model();
        if (rst) begin
            ref_len = 4; ref_ph = 0; ref_cmd = 0;
        end else if (ref_ph == ref_len - 1) begin
            ref_len = long_req ? 6 : 4;
            ref_cmd = int'(next_cmd);
            ref_ph  = 0;
        end else begin
            ref_ph++;
        end
    endtask

    task automatic compare_all();
        chk((ref_len == 6) ? "R2/R3 strobe" : "R1/R3 strobe",
            int'(wr_strobe), (ref_ph == ref_len - 1) ? 1 : 0);
        chk("R4/R8 start", int'(cycle_start), (ref_ph == 0) ? 1 : 0);
        chk("R5/R6 cmd", int'(cmd_out), ref_cmd);
    endtask

    // mode: 0 short, 1 long, 2 alternate per cycle, 3 random every clock
    task automatic run(input int mode, input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1 step_model();
            @(negedge clk);
            compare_all();
            case (mode)
                0: begin long_req = 1'b0; next_cmd = next_cmd + 5'd1; end
                1: begin long_req = 1'b1; next_cmd = next_cmd + 5'd3; end
                2: if (wr_strobe == 1'b0) begin
                       long_req = ~long_req; next_cmd = 5'($urandom);
                   end
                default: begin long_req = 1'($urandom); next_cmd = 5'($urandom); end
            endcase
        end
    endtask

    initial begin
        next_cmd = 5'd9;
        long_req = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R7: state held during reset
        chk("R7 reset start", int'(cycle_start), 1);
        chk("R7 reset strobe", int'(wr_strobe), 0);
        chk("R7 reset cmd", int'(cmd_out), 0);
        rst = 1'b0;
        run(0, 60);
        run(1, 60);
        run(2, 200);
        run(3, 1500);
        // R7: reset in the middle of a long cycle
        long_req = 1'b1; next_cmd = 5'd21;
        run(1, 8);
        rst = 1'b1;
        run(1, 2);
        rst = 1'b0;
        run(1, 1);
        chk("R7 restart cmd", int'(cmd_out), 0);
        run(3, 400);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule